// File: doc/BRIEF.md
# Test Access Port Controller with Two User Scan Instructions

This block is a complete test access port state machine clocked by the test clock. It takes the mode-select and serial data pins and holds an 8-bit instruction register. Two instruction codes, 0x32 and 0x38, are reserved for user scan chains in the core logic. While either one is loaded, the controller hands the core a set of strobes, and the core builds its own data register from them. The strobes are a registered copy of the serial input, shift and update indications, an active-low reset, and one capture/shift enable and one run-test/idle flag for each user instruction.

The core returns serial data on two inputs, one for each user instruction. The input that matches the loaded instruction is sampled on the falling edge of the test clock and drives the serial output pin. Every other instruction connects a single-bit bypass register between the serial input and the serial output. The serial output enable is high only while the controller shifts the instruction register or a data register. A power-on reset input that is active low, and five consecutive clock edges with mode-select high, both return the controller to Test-Logic-Reset.

Top module: `tap_user_bridge`

## Requirements
- R1: While `por_n` is low, and in every Test-Logic-Reset state, `fab_rst_n` is 0 and the instruction register holds the bypass code 0xFF. The bypass code selects neither user instruction, so all user strobes are 0.
- R2: Five consecutive rising edges of `tck` with `tms` high put the controller in Test-Logic-Reset from any state. After only four such edges from Shift-DR, `fab_rst_n` is still 1.
- R3: The instruction register shifts least significant bit first. Capture-IR loads 0x01, so the first eight bits that appear on `tdo` during an instruction shift are 1,0,0,0,0,0,0,0. The shifted value takes effect on the rising edge that leaves Update-IR.
- R4: `fab_tdi` holds the value that `tdi` had at the most recent rising edge of `tck`.
- R5: `fab_shift` is 1 exactly in Shift-DR, and `fab_update` is 1 exactly in Update-DR, whatever the loaded instruction.
- R6: `usr_en1` is 1 only when the instruction is 0x32 and the state is Capture-DR or Shift-DR. `usr_en2` follows the same rule for 0x38.
- R7: `usr_run1` is 1 only when the instruction is 0x32 and the state is Run-Test/Idle. `usr_run2` follows the same rule for 0x38.
- R8: In Shift-DR with instruction 0x32, `tdo` takes the value of `usr_tdo1` sampled on the falling edge of `tck`, and `usr_tdo2` has no effect. With 0x38 the roles of the two inputs are swapped.
- R9: For any other instruction, Capture-DR loads 0 into a 1-bit bypass register. The first bit out on `tdo` is therefore 0, and each following bit is the `tdi` value shifted in one clock earlier.
- R10: `tdo_oe` is updated on the falling edge of `tck` and is 1 only while the state is Shift-IR or Shift-DR.
- R11: `fab_tck` is a direct copy of `tck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| fab_tck | output | 1 | Test clock for the core logic |
| fab_tdi | output | 1 | `tdi` registered on the rising edge |
| fab_shift | output | 1 | High in Shift-DR |
| fab_update | output | 1 | High in Update-DR |
| fab_rst_n | output | 1 | Low in Test-Logic-Reset |
| usr_en1 | output | 1 | Capture/shift enable for instruction 0x32 |
| usr_en2 | output | 1 | Capture/shift enable for instruction 0x38 |
| usr_run1 | output | 1 | Run-Test/Idle flag for instruction 0x32 |
| usr_run2 | output | 1 | Run-Test/Idle flag for instruction 0x38 |
| usr_tdo1 | input | 1 | Core serial return for instruction 0x32 |
| usr_tdo2 | input | 1 | Core serial return for instruction 0x38 |

## Verification
The bench drives the user return input of the instruction that is not selected to the opposite value, so a design that routes the wrong input shows inverted bits on `tdo`. It also checks that `tdo_oe` is high for exactly as many falling edges as there are shift cycles. A design that updates the enable on the rising edge, or one that keeps it high in Exit1, returns a different count and a different bit alignment. In bypass, the bench checks that the first bit out is 0 and that the rest is the input delayed by one clock. A design with no bypass register, or one that does not clear it in Capture-DR, returns a misaligned stream. The bench also checks that four mode-select-high edges are not enough to reset and five are, and that the instruction register returns to bypass afterwards, so a design that resets too early or leaves a user instruction loaded is caught.

// File: rtl/tap_user_bridge.sv
module tap_user_bridge #(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] USR1_OP = 'h32,
  parameter logic [IR_W-1:0] USR2_OP = 'h38,
  parameter logic [IR_W-1:0] BYP_OP  = '1
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic por_n,
  output logic tdo,
  output logic tdo_oe,
  output logic fab_tck,
  output logic fab_tdi,
  output logic fab_shift,
  output logic fab_update,
  output logic fab_rst_n,
  output logic usr_en1,
  output logic usr_en2,
  output logic usr_run1,
  output logic usr_run2,
  input  logic usr_tdo1,
  input  logic usr_tdo2
);

  localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SHIFT_DR, S_EXIT1_DR, S_PAUSE_DR, S_EXIT2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SHIFT_IR, S_EXIT1_IR, S_PAUSE_IR, S_EXIT2_IR, S_UPD_IR
  } tap_st_t;

  tap_st_t state, nxt;
  logic [IR_W-1:0] ir, ir_sr;
  logic byp;
  logic tdo_q, oe_q;

  always_comb begin
    case (state)
      S_TLR:      nxt = tms ? S_TLR      : S_RTI;
      S_RTI:      nxt = tms ? S_SEL_DR   : S_RTI;
      S_SEL_DR:   nxt = tms ? S_SEL_IR   : S_CAP_DR;
      S_CAP_DR:   nxt = tms ? S_EXIT1_DR : S_SHIFT_DR;
      S_SHIFT_DR: nxt = tms ? S_EXIT1_DR : S_SHIFT_DR;
      S_EXIT1_DR: nxt = tms ? S_UPD_DR   : S_PAUSE_DR;
      S_PAUSE_DR: nxt = tms ? S_EXIT2_DR : S_PAUSE_DR;
      S_EXIT2_DR: nxt = tms ? S_UPD_DR   : S_SHIFT_DR;
      S_UPD_DR:   nxt = tms ? S_SEL_DR   : S_RTI;
      S_SEL_IR:   nxt = tms ? S_TLR      : S_CAP_IR;
      S_CAP_IR:   nxt = tms ? S_EXIT1_IR : S_SHIFT_IR;
      S_SHIFT_IR: nxt = tms ? S_EXIT1_IR : S_SHIFT_IR;
      S_EXIT1_IR: nxt = tms ? S_UPD_IR   : S_PAUSE_IR;
      S_PAUSE_IR: nxt = tms ? S_EXIT2_IR : S_PAUSE_IR;
      S_EXIT2_IR: nxt = tms ? S_UPD_IR   : S_SHIFT_IR;
      S_UPD_IR:   nxt = tms ? S_SEL_DR   : S_RTI;
      default:    nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= S_TLR;
    else        state <= nxt;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      ir      <= BYP_OP;
      ir_sr   <= IR_CAP;
      byp     <= 1'b0;
      fab_tdi <= 1'b0;
    end else begin
      fab_tdi <= tdi;
      case (state)
        S_TLR:      ir    <= BYP_OP;
        S_CAP_IR:   ir_sr <= IR_CAP;
        S_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        S_UPD_IR:   ir    <= ir_sr;
        S_CAP_DR:   byp   <= 1'b0;
        S_SHIFT_DR: byp   <= tdi;
        default: ;
      endcase
    end

  wire sel1 = (ir == USR1_OP);
  wire sel2 = (ir == USR2_OP);

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (state == S_SHIFT_IR) || (state == S_SHIFT_DR);
      if (state == S_SHIFT_IR)      tdo_q <= ir_sr[0];
      else if (state == S_SHIFT_DR) tdo_q <= sel1 ? usr_tdo1 : sel2 ? usr_tdo2 : byp;
    end

  assign tdo        = tdo_q;
  assign tdo_oe     = oe_q;
  assign fab_tck    = tck;
  assign fab_shift  = (state == S_SHIFT_DR);
  assign fab_update = (state == S_UPD_DR);
  assign fab_rst_n  = (state != S_TLR);
  assign usr_en1    = sel1 && ((state == S_CAP_DR) || (state == S_SHIFT_DR));
  assign usr_en2    = sel2 && ((state == S_CAP_DR) || (state == S_SHIFT_DR));
  assign usr_run1   = sel1 && (state == S_RTI);
  assign usr_run2   = sel2 && (state == S_RTI);

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n)             tms_run <= '0;
    else if (!tms)          tms_run <= '0;
    else if (tms_run != 5)  tms_run <= tms_run + 3'd1;

  AST_TMS_FIVE: assert property (@(posedge tck) disable iff (!por_n)
    (tms_run == 3'd5) |-> (state == S_TLR)); // R2
  AST_IR_RESET: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR) |=> (ir == BYP_OP)); // R1
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAP_IR) |=> (ir_sr[1:0] == 2'b01)); // R3
  AST_TDI_COPY: assert property (@(posedge tck) disable iff (!por_n)
    1'b1 |=> (fab_tdi == $past(tdi))); // R4
  AST_UPDATE_PATH: assert property (@(posedge tck) disable iff (!por_n)
    fab_update |-> ($past(state) == S_EXIT1_DR || $past(state) == S_EXIT2_DR)); // R5
  AST_IR_HELD_DR: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_SHIFT_DR) |=> $stable(ir)); // R6

endmodule

// File: tb/tap_user_bridge_bench.sv
module tap_user_bridge_bench;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, por_n = 1'b0;
  logic usr_tdo1 = 1'b0, usr_tdo2 = 1'b0;
  logic tdo, tdo_oe, fab_tck, fab_tdi, fab_shift, fab_update, fab_rst_n;
  logic usr_en1, usr_en2, usr_run1, usr_run2;

  tap_user_bridge u_tap_user_bridge (
    .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .tdo(tdo), .tdo_oe(tdo_oe),
    .fab_tck(fab_tck), .fab_tdi(fab_tdi), .fab_shift(fab_shift), .fab_update(fab_update),
    .fab_rst_n(fab_rst_n), .usr_en1(usr_en1), .usr_en2(usr_en2), .usr_run1(usr_run1),
    .usr_run2(usr_run2), .usr_tdo1(usr_tdo1), .usr_tdo2(usr_tdo2));

  always #5 tck = ~tck;

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_q[$];
  logic [7:0] cur_ir = 8'hFF;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge tck) begin
    #2;
    if (tdo_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected tdo_oe", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        chk(tdo == e, "R8/R9/R3 tdo bit", tdo, e);
      end
    end
  end

  task automatic step(input bit t, input bit d);
    tms = t; tdi = d;
    @(posedge tck); #2;
    chk(fab_tdi == d, "R4 fab_tdi", fab_tdi, d);
  endtask

  task automatic ir_scan(input logic [7:0] op);
    step(1, 0); step(1, 0); step(0, 0);
    exp_q.push_back(1'b1);
    for (int i = 1; i < 8; i++) exp_q.push_back(1'b0);
    step(0, 0);
    for (int i = 0; i < 8; i++) step(i == 7, op[i]);
    step(1, 0);
    chk(usr_run1 == 0 && usr_run2 == 0, "R7 no run in Update-IR", usr_run1, 0);
    step(0, 0);
    cur_ir = op;
    chk(usr_run1 == (op == 8'h32), "R3/R7 run1 after update", usr_run1, op == 8'h32);
    chk(usr_run2 == (op == 8'h38), "R3/R7 run2 after update", usr_run2, op == 8'h38);
  endtask

  task automatic dr_scan(input int n, input logic [15:0] din, input logic [15:0] u);
    automatic bit s1 = (cur_ir == 8'h32);
    automatic bit s2 = (cur_ir == 8'h38);
    step(1, 0);
    step(0, 0);
    chk(usr_en1 == s1 && usr_en2 == s2, "R6 enable in Capture-DR", {usr_en1, usr_en2}, {s1, s2});
    chk(fab_shift == 0, "R5 no shift in Capture-DR", fab_shift, 0);
    for (int i = 0; i < n; i++) begin
      if (s1 || s2) exp_q.push_back(u[i]);
      else          exp_q.push_back(i == 0 ? 1'b0 : din[i-1]);
    end
    step(0, 0);
    chk(fab_shift == 1, "R5 shift in Shift-DR", fab_shift, 1);
    chk(usr_en1 == s1 && usr_en2 == s2, "R6 enable in Shift-DR", {usr_en1, usr_en2}, {s1, s2});
    for (int i = 0; i < n; i++) begin
      usr_tdo1 = s2 ? ~u[i] : u[i];
      usr_tdo2 = s1 ? ~u[i] : u[i];
      step(i == n - 1, din[i]);
    end
    chk(usr_en1 == 0 && usr_en2 == 0 && fab_shift == 0, "R5/R6 idle in Exit1-DR", usr_en1, 0);
    step(1, 0);
    chk(fab_update == 1, "R5 update in Update-DR", fab_update, 1);
    step(0, 0);
    chk(fab_update == 0, "R5 update cleared", fab_update, 0);
    chk(usr_run1 == s1 && usr_run2 == s2, "R7 run flags in idle", {usr_run1, usr_run2}, {s1, s2});
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #2;
    chk(fab_rst_n == 0, "R1 reset output in power-on reset", fab_rst_n, 0);
    chk(tdo_oe == 0, "R10 oe low in reset", tdo_oe, 0);
    chk({usr_en1, usr_en2, usr_run1, usr_run2} == 0, "R1 user strobes low", usr_en1, 0);
    chk(fab_tck == tck, "R11 clock copy high phase", fab_tck, tck);
    por_n = 1'b1;
    step(0, 0);
    chk(fab_rst_n == 1, "R1 leaves reset", fab_rst_n, 1);
    chk(usr_run1 == 0 && usr_run2 == 0, "R1 bypass after reset", usr_run1, 0);
    #4;
    chk(fab_tck == tck, "R11 clock copy low phase", fab_tck, tck);
    #6;
    dr_scan(6, 16'b101101, 16'h0);
    ir_scan(8'h32);
    dr_scan(8, 16'h5A, 16'hC3);
    ir_scan(8'h38);
    dr_scan(7, 16'h11, 16'h4B);
    ir_scan(8'hA5);
    dr_scan(5, 16'b10011, 16'h1F);
    ir_scan(8'h38);
    step(1, 0); step(0, 0); step(0, 0);
    chk(fab_shift == 1, "R5 in Shift-DR before reset run", fab_shift, 1);
    exp_q.push_back(1'b0);
    usr_tdo2 = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 0);
    chk(fab_rst_n == 1, "R2 four edges do not reset", fab_rst_n, 1);
    step(1, 0);
    chk(fab_rst_n == 0, "R2 five edges reset", fab_rst_n, 0);
    cur_ir = 8'hFF;
    step(0, 0);
    chk(usr_run2 == 0 && usr_run1 == 0, "R1 IR back to bypass", usr_run2, 0);
    dr_scan(4, 16'b0110, 16'hF);
    repeat (3) @(posedge tck);
    chk(exp_q.size() == 0, "R10 all expected bits seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule